// File: doc/BRIEF.md
# Dual-Rail Handshaked Gate Stage

This block is a clock-sampled model of a single gate-sized stage in a fine-grain self-timed pipeline. Each of its two operand channels carries one logical bit on a pair of wires, rail 0 and rail 1, together with a request wire. The stage answers both producers on one shared acknowledge wire. The stage evaluates a two-input Boolean function on the operands. It holds the result on a dual-rail output channel with its own request, and it broadcasts that result to several consumers.

Data moves in four phases with a return to zero. A value is taken only when both operands carry legal codes and both requests are high. The result stays on the output until every consumer has acknowledged. The output then returns to the all-low spacer. The upstream acknowledge comes from completion detection on the output. It drops only once the output and both operand channels are back at the spacer. A parameter chooses an AND or an OR function. The OR version reuses the AND evaluation network with the rails of the operands and of the result exchanged. An operand with both rails high is illegal and sets an error flag that stays set.

Top module: `dr_gate_stage`

## Requirements
- R1: After reset the output pair is the spacer (both rails low), and out_req, in_ack and err are all 0.
- R2: A channel code is written {rail1, rail0}. 2'b00 is the spacer, 2'b01 is logic 0, 2'b10 is logic 1 and 2'b11 is illegal. With USE_OR=0 the output token is the AND of the two operand values. It appears one clock edge after the cycle in which the stage accepts the operands.
- R3: With USE_OR=1 the output token is the OR of the two operand values, with the same timing as R2.
- R4: The stage produces a token only when both operand requests are high and both operand pairs hold legal codes. One operand alone, or operand data without its request, leaves the output at the spacer.
- R5: A token stays unchanged on the output until all FANOUT bits of out_ack are high in the same cycle. On the first clock edge with all of them high, the output returns to the spacer.
- R6: in_ack rises one clock edge after the output holds a token. It falls one clock edge after the output, both operand pairs and both operand requests are all low.
- R7: While in_ack is high the stage accepts no new operands. Operands held after the token is released do not produce a second token.
- R8: A 2'b11 code on either operand sets err one clock edge later. The illegal operand is not evaluated, and err stays set until reset.
- R9: out_req is high exactly while the output pair holds a token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| a_r0 | input | 1 | Operand A, rail 0 |
| a_r1 | input | 1 | Operand A, rail 1 |
| a_req | input | 1 | Operand A request |
| b_r0 | input | 1 | Operand B, rail 0 |
| b_r1 | input | 1 | Operand B, rail 1 |
| b_req | input | 1 | Operand B request |
| in_ack | output | 1 | Acknowledge shared by both producers |
| out_r0 | output | 1 | Result, rail 0 |
| out_r1 | output | 1 | Result, rail 1 |
| out_req | output | 1 | Result request |
| out_ack | input | FANOUT | Acknowledges from the consumers |
| err | output | 1 | Sticky illegal-code flag |

## Verification
Wrong internal state shows up at the ports within one or two clock edges. A bad evaluation shows as the wrong rail on the output in the cycle after acceptance. A missed synchronizer shows as a token while one operand is still absent. A weak completion detector shows as in_ack moving one edge too early or too late, or as a second token produced from held operands. Partial consumer acknowledges are held for several cycles to expose an early release, and an illegal operand is followed by spacer cycles to show whether err stays set.

// File: rtl/dr_gate_stage.sv
module dr_gate_stage #(
  parameter bit          USE_OR = 1'b0,
  parameter int unsigned FANOUT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_r0,
  input  logic              a_r1,
  input  logic              a_req,
  input  logic              b_r0,
  input  logic              b_r1,
  input  logic              b_req,
  output logic              in_ack,
  output logic              out_r0,
  output logic              out_r1,
  output logic              out_req,
  input  logic [FANOUT-1:0] out_ack,
  output logic              err
);

  logic x0, x1, y0, y1, c0, c1, f0, f1;

  generate
    if (USE_OR) begin : g_or
      assign x0 = a_r1;
      assign x1 = a_r0;
      assign y0 = b_r1;
      assign y1 = b_r0;
      assign f1 = c0;
      assign f0 = c1;
    end else begin : g_and
      assign x0 = a_r0;
      assign x1 = a_r1;
      assign y0 = b_r0;
      assign y1 = b_r1;
      assign f1 = c1;
      assign f0 = c0;
    end
  endgenerate

  assign c1 = x1 & y1;
  assign c0 = x0 | y0;

  wire a_ok    = a_r0 ^ a_r1;
  wire b_ok    = b_r0 ^ b_r1;
  wire bad     = (a_r0 & a_r1) | (b_r0 & b_r1);
  wire in_null = ~a_r0 & ~a_r1 & ~b_r0 & ~b_r1 & ~a_req & ~b_req;
  wire done    = out_r0 | out_r1;
  wire take    = ~done & ~in_ack & ~(|out_ack) & a_req & b_req & a_ok & b_ok;
  wire release_tok = done & (&out_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r0  <= 1'b0;
      out_r1  <= 1'b0;
      out_req <= 1'b0;
      in_ack  <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (take) begin
        out_r0  <= f0;
        out_r1  <= f1;
        out_req <= 1'b1;
      end else if (release_tok) begin
        out_r0  <= 1'b0;
        out_r1  <= 1'b0;
        out_req <= 1'b0;
      end
      if (done)
        in_ack <= 1'b1;
      else if (in_null)
        in_ack <= 1'b0;
      err <= err | bad;
    end
  end

endmodule

module dr_gate_stage_chk #(
  parameter int unsigned FANOUT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_req,
  input logic              b_req,
  input logic              in_ack,
  input logic              out_r0,
  input logic              out_r1,
  input logic              out_req,
  input logic [FANOUT-1:0] out_ack,
  input logic              err
);

  p_no_code11_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_r0 && out_r1));

  p_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(a_req && b_req));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !(&out_ack)) |=> (out_req && $stable({out_r1, out_r0})));

  p_ack_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(out_r0 || out_r1));

  p_ack_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> $past(!a_req && !b_req && !out_r0 && !out_r1));

  p_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> $past(!in_ack));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_req_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_req == (out_r0 || out_r1));

endmodule

bind dr_gate_stage dr_gate_stage_chk #(.FANOUT(FANOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_req(a_req), .b_req(b_req), .in_ack(in_ack),
  .out_r0(out_r0), .out_r1(out_r1), .out_req(out_req), .out_ack(out_ack),
  .err(err)
);

// File: tb/tb_dr_gate_stage.sv
module tb_dr_gate_stage;
  localparam int FO = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_r0 = 0, a_r1 = 0, a_req = 0, b_r0 = 0, b_r1 = 0, b_req = 0;
  logic [FO-1:0] oack = '0;
  logic ack_n, z0_n, z1_n, zq_n, err_n;
  logic ack_o, z0_o, z1_o, zq_o, err_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dr_gate_stage #(.USE_OR(1'b0), .FANOUT(FO)) dut (
    .clk(clk), .rst_n(rst_n), .a_r0(a_r0), .a_r1(a_r1), .a_req(a_req),
    .b_r0(b_r0), .b_r1(b_r1), .b_req(b_req), .in_ack(ack_n),
    .out_r0(z0_n), .out_r1(z1_n), .out_req(zq_n), .out_ack(oack), .err(err_n));

  dr_gate_stage #(.USE_OR(1'b1), .FANOUT(FO)) dut_or (
    .clk(clk), .rst_n(rst_n), .a_r0(a_r0), .a_r1(a_r1), .a_req(a_req),
    .b_r0(b_r0), .b_r1(b_r1), .b_req(b_req), .in_ack(ack_o),
    .out_r0(z0_o), .out_r1(z1_o), .out_req(zq_o), .out_ack(oack), .err(err_o));

  function automatic logic [1:0] enc(input bit v);
    return v ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [3:0] act, input logic [3:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic set_in(input logic [1:0] a, input bit ar, input logic [1:0] b, input bit br);
    {a_r1, a_r0} = a; a_req = ar;
    {b_r1, b_r0} = b; b_req = br;
  endtask

  task automatic token(input bit av, input bit bv, input int dwell, input bit keep);
    logic [1:0] ea, eo;
    ea = enc(av & bv);
    eo = enc(av | bv);
    @(negedge clk);
    set_in(enc(av), 1, enc(bv), 1);
    @(negedge clk);
    chk_eq("R2 and token", {z1_n, z0_n}, ea);
    chk_eq("R3 or token", {z1_o, z0_o}, eo);
    chk_eq("R9 req with token", {zq_n, zq_o}, 2'b11);
    chk_eq("R6 ack not yet", {ack_n, ack_o}, 2'b00);
    @(negedge clk);
    chk_eq("R6 ack risen", {ack_n, ack_o}, 2'b11);
    if (!keep) set_in(2'b00, 0, 2'b00, 0);
    for (int i = 0; i < dwell; i++) begin
      oack = FO'($urandom % ((1 << FO) - 1));
      @(negedge clk);
      chk_eq("R5 held on partial ack", {z1_n, z0_n, z1_o, z0_o}, {ea, eo});
    end
    oack = '1;
    @(negedge clk);
    chk_eq("R5 released", {z1_n, z0_n, z1_o, z0_o}, 4'h0);
    chk_eq("R9 req low", {zq_n, zq_o}, 2'b00);
    oack = '0;
    if (keep) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk_eq("R7 no second token", {z1_n, z0_n, z1_o, z0_o}, 4'h0);
        chk_eq("R7 ack held", {ack_n, ack_o}, 2'b11);
      end
      set_in(2'b00, 0, 2'b00, 0);
    end
    @(negedge clk);
    chk_eq("R6 ack fallen", {ack_n, ack_o}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk_eq("R1 reset outputs", {z1_n, z0_n, zq_n, ack_n}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 after reset", {z1_o, z0_o, zq_o, ack_o}, 4'h0);
    chk_eq("R1 err clear", {err_n, err_o}, 2'b00);

    for (int v = 0; v < 4; v++) token(v[1], v[0], 2, 0);

    set_in(enc(1), 1, 2'b00, 0);
    repeat (3) begin
      @(negedge clk);
      chk_eq("R4 one operand only", {z1_n, z0_n, z1_o, z0_o}, 4'h0);
    end
    set_in(enc(1), 1, enc(0), 0);
    repeat (2) begin
      @(negedge clk);
      chk_eq("R4 data without req", {zq_n, zq_o}, 2'b00);
    end
    set_in(2'b00, 0, 2'b00, 0);
    @(negedge clk);

    token(1, 1, 3, 1);
    token(0, 1, 0, 0);

    for (int n = 0; n < 40; n++)
      token($urandom % 2, $urandom % 2, $urandom % 4, ($urandom % 8) == 0);

    set_in(2'b11, 1, enc(1), 1);
    @(negedge clk);
    chk_eq("R8 err set", {err_n, err_o}, 2'b11);
    chk_eq("R8 not evaluated", {z1_n, z0_n, z1_o, z0_o}, 4'h0);
    set_in(2'b00, 0, 2'b00, 0);
    repeat (3) @(negedge clk);
    chk_eq("R8 err sticky", {err_n, err_o}, 2'b11);
    token(1, 0, 1, 0);
    chk_eq("R8 err still set", {err_n, err_o}, 2'b11);

    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R1 reset clears err", {err_n, err_o}, 2'b00);
    rst_n = 1'b1;
    token(1, 1, 1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule